// File: doc/BRIEF.md
# Banked LED Latch Loader

This block keeps a bank of external LED latches up to date. Twenty-one LEDs sit in four 6-bit latches. The latches share one 6-bit data bus, and each latch is clocked by one output of an external 3-to-8 decoder. The host presents the whole LED picture as a 21-bit vector. Whenever that vector differs from what was last written, or whenever the host pulses a refresh tick, the block runs one pass. A pass writes every latch in ascending order.

The latch clock is never driven directly. The block parks the decoder on an address that clocks nothing, places the data, and then steps the address to the latch's own output. It holds that address for a fixed number of cycles and then parks again. The decoder's three enables are asserted only while a pass runs. Latch bits that carry no LED are driven to a fixed tie level. After reset the block runs one pass with every LED off, before any host request is served.

Top module: `led_bank_loader`

## Requirements
- R1: After reset is released, the block starts a pass on the next clock edge. That pass writes every LED bit as 0 (off) into all four latches, whatever the LED vector holds.
- R2: LED vector bit i is written to latch i/6, bit i%6. LED data is active high: 1 lights the LED. Latch k is clocked by decoder output k+1.
- R3: Latch 3 bits 3 to 5 carry no LED and are driven to 1 each time latch 3 is written.
- R4: While a pass runs, both active-low decoder enables are 0 and the active-high enable is 1. While idle they are 1, 1 and 0.
- R5: The data bus changes value only in a cycle in which the decoder address is the park address 0.
- R6: The data bus holds its value for at least one cycle before the address steps from park to a latch address.
- R7: Each latch address is held for exactly 2 consecutive cycles, and then the address returns to park.
- R8: Each pass writes latches 0, 1, 2 and 3 in that order, once each.
- R9: A change of the LED vector while idle starts a pass. Busy is high one clock edge after the change is sampled.
- R10: A refresh tick while idle starts a pass that rewrites the unchanged vector.
- R11: A refresh tick, or a vector change, that arrives during a pass causes a further pass after the current one. That pass writes the latest vector.
- R12: Busy is high for the whole of a pass. With no tick and no vector change, no pass runs and the address stays at park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| led_vec | input | 21 | Requested LED state, 1 = lit |
| refresh_tick | input | 1 | One-cycle request to rewrite all latches |
| bank_data | output | 6 | Shared latch data bus |
| dec_sel | output | 3 | Decoder address (0 = park) |
| dec_en_lo_a | output | 1 | Decoder enable, active low |
| dec_en_lo_b | output | 1 | Decoder enable, active low |
| dec_en_hi | output | 1 | Decoder enable, active high |
| busy | output | 1 | A pass is in progress |

## Verification
The bench models the external latches. Each one captures the data bus on the cycle its decoder output becomes selected, so a mapping or tie-off error shows up as a wrong latch image. The bench also watches every edge of a pass:
- Data that moves while a latch address is live would tear a latch.
- An address that dwells one cycle too long or too short is a clock-width fault.
- A latch written out of order breaks the ascending sequence.

Requests that land in the middle of a pass are the sharpest corner. A design that drops them leaves stale LEDs, or does not rewrite the latches when the host asked. The power-up pass is checked with a non-zero vector already present, so a design that skips the all-off pass is caught.

// File: rtl/led_bank_pkg.sv
package led_bank_pkg;

   // Pass sequencer phases: park with old data, setup with new data, strike
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_GAP    = 2'd1,
      SEQ_SETUP  = 2'd2,
      SEQ_STRIKE = 2'd3
   } seq_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/led_bank_trigger.sv
module led_bank_trigger #(
   parameter int NUM_LEDS = 21
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEDS-1:0] led_vec,
   input  logic                refresh_tick,
   input  logic                seq_busy,
   output logic                start,
   output logic [NUM_LEDS-1:0] snap
);

   logic                boot_q;
   logic                pend_q;
   logic [NUM_LEDS-1:0] applied_q;
   logic                want;

   // A pass is wanted at power-up, on a stored request, on a tick or on a new vector
   assign want  = boot_q | pend_q | refresh_tick | (led_vec != applied_q);
   assign start = want & ~seq_busy;
   assign snap  = applied_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         boot_q    <= 1'b1;
         pend_q    <= 1'b0;
         applied_q <= '0;
      end else if (start) begin
         boot_q    <= 1'b0;
         pend_q    <= 1'b0;
         applied_q <= boot_q ? '0 : led_vec;
      end else if (seq_busy && refresh_tick) begin
         pend_q    <= 1'b1;
      end
   end

endmodule

// File: rtl/led_bank_mapper.sv
module led_bank_mapper #(
   parameter int   NUM_LEDS       = 21,
   parameter int   REG_W          = 6,
   parameter int   NUM_REGS       = 4,
   parameter bit   LED_ACTIVE_LOW = 1'b0,
   parameter bit   TIE_LEVEL      = 1'b1
) (
   input  logic [NUM_LEDS-1:0]             snap,
   output logic [NUM_REGS-1:0][REG_W-1:0]  words
);

   localparam int SLOTS = NUM_REGS * REG_W;

   initial begin
      if (SLOTS < NUM_LEDS)
         $error("led_bank_mapper: %0d latch bits cannot hold %0d LEDs", SLOTS, NUM_LEDS);
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      for (genvar b = 0; b < REG_W; b++) begin : g_bit
         localparam int POS = k * REG_W + b;
         if (POS < NUM_LEDS) begin : g_led
            if (LED_ACTIVE_LOW) begin : g_inv
               assign words[k][b] = ~snap[POS];
            end else begin : g_pass
               assign words[k][b] = snap[POS];
            end
         end else begin : g_tie
            assign words[k][b] = TIE_LEVEL;
         end
      end
   end

endmodule

// File: rtl/led_bank_sequencer.sv
module led_bank_sequencer
   import led_bank_pkg::*;
#(
   parameter int REG_W     = 6,
   parameter int NUM_REGS  = 4,
   parameter int ADDR_W    = 3,
   parameter int PARK_ADDR = 0,
   parameter int BASE_OUT  = 1,
   parameter int SETUP_CYC = 1,
   parameter int HOLD_CYC  = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [NUM_REGS-1:0][REG_W-1:0]  words,
   output logic [REG_W-1:0]                bank_data,
   output logic [ADDR_W-1:0]               dec_sel,
   output logic                            dec_en_lo_a,
   output logic                            dec_en_lo_b,
   output logic                            dec_en_hi,
   output logic                            busy
);

   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int CNT_W = $clog2(max2(SETUP_CYC, HOLD_CYC) + 1);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_REGS - 1);
   localparam logic [CNT_W-1:0]  SETUP_END = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0]  HOLD_END  = CNT_W'(HOLD_CYC - 1);
   localparam logic [ADDR_W-1:0] PARK      = ADDR_W'(PARK_ADDR);
   localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(BASE_OUT);

   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic [REG_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_GAP;
                  idx_q   <= '0;
                  cnt_q   <= '0;
               end
            end
            SEQ_GAP: begin
               // address already parked; new data goes out now
               state_q <= SEQ_SETUP;
               data_q  <= words[idx_q];
               cnt_q   <= '0;
            end
            SEQ_SETUP: begin
               if (cnt_q == SETUP_END) begin
                  state_q <= SEQ_STRIKE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
               end
            end
            SEQ_STRIKE: begin
               if (cnt_q == HOLD_END) begin
                  cnt_q <= '0;
                  if (idx_q == LAST_IDX) begin
                     state_q <= SEQ_IDLE;
                  end else begin
                     state_q <= SEQ_GAP;
                     idx_q   <= idx_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != SEQ_IDLE);
   assign bank_data   = data_q;
   assign dec_sel     = (state_q == SEQ_STRIKE) ? (BASE + ADDR_W'(idx_q)) : PARK;
   assign dec_en_lo_a = ~busy;
   assign dec_en_lo_b = ~busy;
   assign dec_en_hi   = busy;

endmodule

// File: rtl/led_bank_loader.sv
module led_bank_loader #(
   parameter int NUM_LEDS       = 21,
   parameter int REG_W          = 6,
   parameter int NUM_REGS       = 4,
   parameter int ADDR_W         = 3,
   parameter int PARK_ADDR      = 0,
   parameter int BASE_OUT       = 1,
   parameter int SETUP_CYC      = 1,
   parameter int HOLD_CYC       = 2,
   parameter bit LED_ACTIVE_LOW = 1'b0,
   parameter bit TIE_LEVEL      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEDS-1:0] led_vec,
   input  logic                refresh_tick,
   output logic [REG_W-1:0]    bank_data,
   output logic [ADDR_W-1:0]   dec_sel,
   output logic                dec_en_lo_a,
   output logic                dec_en_lo_b,
   output logic                dec_en_hi,
   output logic                busy
);

   localparam int LAST_OUT = BASE_OUT + NUM_REGS - 1;

   initial begin
      if (LAST_OUT >= (1 << ADDR_W))
         $error("led_bank_loader: latch outputs exceed the decoder range");
      if (PARK_ADDR >= BASE_OUT && PARK_ADDR <= LAST_OUT)
         $error("led_bank_loader: park address collides with a latch output");
      if (PARK_ADDR >= (1 << ADDR_W))
         $error("led_bank_loader: park address outside decoder range");
      if (SETUP_CYC < 1 || HOLD_CYC < 1 || HOLD_CYC > 200)
         $error("led_bank_loader: setup/hold cycle counts out of range");
      if (NUM_REGS < 1 || REG_W < 1)
         $error("led_bank_loader: empty latch bank");
   end

   logic                           start;
   logic [NUM_LEDS-1:0]            snap;
   logic [NUM_REGS-1:0][REG_W-1:0] words;

   led_bank_trigger #(
      .NUM_LEDS (NUM_LEDS)
   ) u_trigger (
      .clk          (clk),
      .rst_n        (rst_n),
      .led_vec      (led_vec),
      .refresh_tick (refresh_tick),
      .seq_busy     (busy),
      .start        (start),
      .snap         (snap)
   );

   led_bank_mapper #(
      .NUM_LEDS       (NUM_LEDS),
      .REG_W          (REG_W),
      .NUM_REGS       (NUM_REGS),
      .LED_ACTIVE_LOW (LED_ACTIVE_LOW),
      .TIE_LEVEL      (TIE_LEVEL)
   ) u_mapper (
      .snap  (snap),
      .words (words)
   );

   led_bank_sequencer #(
      .REG_W     (REG_W),
      .NUM_REGS  (NUM_REGS),
      .ADDR_W    (ADDR_W),
      .PARK_ADDR (PARK_ADDR),
      .BASE_OUT  (BASE_OUT),
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .words       (words),
      .bank_data   (bank_data),
      .dec_sel     (dec_sel),
      .dec_en_lo_a (dec_en_lo_a),
      .dec_en_lo_b (dec_en_lo_b),
      .dec_en_hi   (dec_en_hi),
      .busy        (busy)
   );

endmodule

// File: rtl/led_bank_loader_chk.sv
module led_bank_loader_chk #(
   parameter int NUM_LEDS  = 21,
   parameter int REG_W     = 6,
   parameter int NUM_REGS  = 4,
   parameter int ADDR_W    = 3,
   parameter int PARK_ADDR = 0,
   parameter int BASE_OUT  = 1,
   parameter int HOLD_CYC  = 2,
   parameter bit TIE_LEVEL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_W-1:0]  bank_data,
   input logic [ADDR_W-1:0] dec_sel,
   input logic              dec_en_lo_a,
   input logic              dec_en_lo_b,
   input logic              dec_en_hi,
   input logic              busy
);

   localparam int UNUSED = NUM_REGS * REG_W - NUM_LEDS;
   localparam logic [REG_W-1:0] TIE_MASK =
      REG_W'(((1 << UNUSED) - 1) << (REG_W - UNUSED));
   localparam logic [REG_W-1:0] TIE_VAL  = TIE_LEVEL ? TIE_MASK : '0;
   localparam logic [ADDR_W-1:0] PARK     = ADDR_W'(PARK_ADDR);
   localparam logic [ADDR_W-1:0] LAST_SEL = ADDR_W'(BASE_OUT + NUM_REGS - 1);

   // length of the current run of non-park addresses
   logic [7:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)            run_q <= '0;
      else if (dec_sel != PARK) run_q <= run_q + 8'd1;
      else                   run_q <= '0;
   end

   a_r4_enables_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dec_en_lo_a && dec_en_lo_b && !dec_en_hi));

   a_r4_enables_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!dec_en_lo_a && !dec_en_lo_b && dec_en_hi));

   a_r5_data_moves_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_data) |-> (dec_sel == PARK));

   a_r6_setup_before_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_sel != PARK && $past(dec_sel) == PARK) |-> $stable(bank_data));

   a_r7_hold_width: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_sel == PARK && run_q != 8'd0) |-> (run_q == 8'(HOLD_CYC)));

   a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 8'(HOLD_CYC));

   a_r3_tie_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_sel == LAST_SEL) |-> ((bank_data & TIE_MASK) == TIE_VAL));

   a_r12_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dec_sel == PARK));

endmodule

bind led_bank_loader led_bank_loader_chk #(
   .NUM_LEDS  (NUM_LEDS),
   .REG_W     (REG_W),
   .NUM_REGS  (NUM_REGS),
   .ADDR_W    (ADDR_W),
   .PARK_ADDR (PARK_ADDR),
   .BASE_OUT  (BASE_OUT),
   .HOLD_CYC  (HOLD_CYC),
   .TIE_LEVEL (TIE_LEVEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bank_data   (bank_data),
   .dec_sel     (dec_sel),
   .dec_en_lo_a (dec_en_lo_a),
   .dec_en_lo_b (dec_en_lo_b),
   .dec_en_hi   (dec_en_hi),
   .busy        (busy)
);

// File: tb/tb_led_bank_loader.sv
module tb_led_bank_loader;

   localparam int CLK_PERIOD = 10;
   localparam int NL   = 21;
   localparam int RW   = 6;
   localparam int NR   = 4;
   localparam int PARK = 0;
   localparam int BASE = 1;
   localparam int HOLD = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] led_vec = '0;
   logic          refresh_tick = 1'b0;
   logic [RW-1:0] bank_data;
   logic [2:0]    dec_sel;
   logic          dec_en_lo_a, dec_en_lo_b, dec_en_hi, busy;

   led_bank_loader dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .led_vec      (led_vec),
      .refresh_tick (refresh_tick),
      .bank_data    (bank_data),
      .dec_sel      (dec_sel),
      .dec_en_lo_a  (dec_en_lo_a),
      .dec_en_lo_b  (dec_en_lo_b),
      .dec_en_hi    (dec_en_hi),
      .busy         (busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---- external latch model: capture on entry into the latch's decoder output
   logic [RW-1:0] mreg [NR];
   logic [NR-1:0] prev_hit = '0;
   int            run [NR];
   int            strikes = 0;
   int            exp_idx = 0;
   logic [RW-1:0] prev_data = '0;
   bit            mon_first = 1'b1;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_hit  = '0;
         exp_idx   = 0;
         mon_first = 1'b1;
      end else begin
         for (int k = 0; k < NR; k++) begin
            bit hit;
            hit = !dec_en_lo_a && !dec_en_lo_b && dec_en_hi && (dec_sel == 3'(BASE + k));
            if (hit && !prev_hit[k]) begin
               chk(k == exp_idx, "R8", "latch order", k, exp_idx);
               if (!mon_first)
                  chk(bank_data == prev_data, "R6", "data stable before step", bank_data, prev_data);
               mreg[k] = bank_data;
               strikes++;
               exp_idx = (k + 1) % NR;
               run[k]  = 1;
            end else if (hit) begin
               run[k]++;
            end else if (prev_hit[k]) begin
               chk(run[k] == HOLD, "R7", "target hold cycles", run[k], HOLD);
            end
            prev_hit[k] = hit;
         end
         if (!mon_first && bank_data != prev_data)
            chk(dec_sel == 3'(PARK), "R5", "address when data moves", dec_sel, PARK);
         prev_data = bank_data;
         mon_first = 1'b0;
      end
   end

   function automatic logic [RW-1:0] exp_word(input logic [NL-1:0] v, input int k);
      logic [RW-1:0] w;
      for (int b = 0; b < RW; b++) begin
         int i;
         i = k * RW + b;
         w[b] = (i < NL) ? v[i] : 1'b1;
      end
      return w;
   endfunction

   task automatic check_regs(input logic [NL-1:0] v, input string req);
      for (int k = 0; k < NR; k++)
         chk(mreg[k] === exp_word(v, k), req, $sformatf("latch %0d image", k), mreg[k], exp_word(v, k));
   endtask

   task automatic wait_idle();
      int low = 0;
      int n = 0;
      while (low < 4 && n < 2000) begin
         @(negedge clk);
         n++;
         if (!busy) low++;
         else       low = 0;
      end
      chk(n < 2000, "R12", "pass completes", n, 2000);
   endtask

   // ---- scenarios
   task automatic t_reset();
      led_vec = 21'h0ABCDE;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R12", "busy in reset", busy, 0);
      chk(dec_sel == 3'(PARK), "R12", "address in reset", dec_sel, PARK);
      chk({dec_en_lo_a, dec_en_lo_b, dec_en_hi} == 3'b110, "R4", "enables idle",
          {dec_en_lo_a, dec_en_lo_b, dec_en_hi}, 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R1", "power-up pass started", busy, 1);
      chk({dec_en_lo_a, dec_en_lo_b, dec_en_hi} == 3'b001, "R4", "enables in pass",
          {dec_en_lo_a, dec_en_lo_b, dec_en_hi}, 3'b001);
      // wait only for the all-off pass: its last strike ends it
      while (busy) @(negedge clk);
      chk(strikes == 4, "R1", "power-up strikes", strikes, 4);
      check_regs('0, "R1");
      check_regs('0, "R3");
      // the waiting vector then gets its own pass
      wait_idle();
      check_regs(led_vec, "R2");
   endtask

   task automatic t_vector(input logic [NL-1:0] v);
      int s0 = strikes;
      led_vec = v;
      @(negedge clk);
      chk(busy == 1'b1, "R9", "pass starts on change", busy, 1);
      wait_idle();
      chk(strikes == s0 + 4, "R8", "strikes per pass", strikes, s0 + 4);
      check_regs(v, "R2");
      chk(mreg[3][5:3] == 3'b111, "R3", "tie bits", mreg[3][5:3], 3'b111);
   endtask

   task automatic t_quiet();
      int s0 = strikes;
      bit seen = 1'b0;
      repeat (40) begin
         @(negedge clk);
         if (busy || dec_sel != 3'(PARK)) seen = 1'b1;
      end
      chk(!seen, "R12", "no pass without request", seen, 0);
      chk(strikes == s0, "R12", "no strikes when quiet", strikes, s0);
   endtask

   task automatic t_tick();
      int s0 = strikes;
      refresh_tick = 1'b1;
      @(negedge clk);
      refresh_tick = 1'b0;
      chk(busy == 1'b1, "R10", "tick starts pass", busy, 1);
      wait_idle();
      chk(strikes == s0 + 4, "R10", "tick pass strikes", strikes, s0 + 4);
      check_regs(led_vec, "R10");
   endtask

   task automatic t_change_busy(input logic [NL-1:0] a, input logic [NL-1:0] b);
      int s0 = strikes;
      led_vec = a;
      @(negedge clk);
      repeat (5) @(negedge clk);
      led_vec = b;
      wait_idle();
      chk(strikes == s0 + 8, "R11", "change during pass strikes", strikes, s0 + 8);
      check_regs(b, "R11");
   endtask

   task automatic t_tick_busy();
      int s0 = strikes;
      refresh_tick = 1'b1;
      @(negedge clk);
      refresh_tick = 1'b0;
      repeat (6) @(negedge clk);
      refresh_tick = 1'b1;
      @(negedge clk);
      refresh_tick = 1'b0;
      wait_idle();
      chk(strikes == s0 + 8, "R11", "tick during pass strikes", strikes, s0 + 8);
      check_regs(led_vec, "R11");
   endtask

   bit done = 1'b0;

   initial begin
      t_reset();
      t_vector(21'h1FFFFF);
      t_vector(21'h155555);
      t_vector(21'h000001);
      t_vector(21'h000020);
      t_vector(21'h000040);
      t_vector(21'h100000);
      t_quiet();
      t_tick();
      t_change_busy(21'h0F0F0F, 21'h12345);
      t_tick_busy();
      t_vector(21'h000000);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule